// File: doc/BRIEF.md
# Invalidation Receive Queue with Load Fencing

This block sits on the receiving end of a cache coherence invalidation path for one core. A remote agent that wants to write a line sends the line address over a valid/ready port. The block accepts it as soon as there is room in its queue, so the requester gets its acknowledgement at once. Each queued address is applied later to the local line-state array, and a matching line is moved to Invalid. Between acknowledgement and application, the local core can still look the line up and hit on the old copy. This stale-read window is intended.

Two fence inputs close that window. A load fence or a full fence takes the load-permit output low. It stays low until every queued invalidation has been applied, and it is held low for one more cycle. The core must not complete a load while the permit is low. The line-state array belongs to the block and shares one update port between line fills and invalidation application.

The invalidation input follows valid/ready rules. A transfer happens on a clock edge where `inv_valid` and `inv_ready` are both high. While `inv_valid` is high and `inv_ready` is low, the requester keeps `inv_valid` and `inv_addr` stable. `inv_ready` depends only on queue occupancy. The fill, lookup, fence and apply-observation pins are plain signals.

Top module: `inval_queue`

## Requirements
- R1: An accepted invalidation counts as acknowledged on the edge where it transfers. It is queued but not yet applied, so in the cycle after acceptance the queue is non-empty and the line state is unchanged.
- R2: `inv_ready` is high whenever fewer than DEPTH invalidations are queued. It is low when DEPTH are queued, and no request is taken until an entry leaves.
- R3: When `fill_valid` is low and the queue is not empty, exactly one queued address is applied per cycle, in arrival order. `apply_valid` and `apply_addr` show each address in the cycle it is applied. A fill takes the update port, and no entry is applied in a cycle where `fill_valid` is high.
- R4: Line state encoding is 0 = Invalid, 1 = Shared, 2 = Exclusive, 3 = Modified. The set index is `addr[SET_W-1:0]` and the tag is the remaining upper bits. Applying an address whose set holds a valid line with an equal tag moves that line to Invalid, whichever valid state it held.
- R5: Applying an address that is not present has no effect on the line-state array. This covers a tag mismatch or an Invalid set.
- R6: Until its invalidation is applied, a lookup of a line still reports a hit with its previous state on `ld_hit` and `ld_state`. `ld_hit` and `ld_state` are combinational from `ld_addr`.
- R7: `fence_ld` drives `load_permit` low in the same cycle. The permit stays low until a cycle in which the fence is pending and the queue is empty, and it returns high on the next cycle. With an empty queue, the permit is therefore low for two cycles.
- R8: `fence_full` has the same effect on `load_permit` as `fence_ld`.
- R9: Once `load_permit` returns high after a fence, no invalidation accepted before that fence can still produce a hit.
- R10: After reset the queue is empty, every line is Invalid, `inv_ready` and `load_permit` are high, and `apply_valid` and `ld_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidation request valid |
| inv_ready | output | 1 | Queue can accept a request (acknowledge) |
| inv_addr | input | ADDR_W | Line address to invalidate |
| apply_valid | output | 1 | A queued invalidation is applied this cycle |
| apply_addr | output | ADDR_W | Address being applied |
| fill_valid | input | 1 | Write a line into the state array (takes the update port) |
| fill_addr | input | ADDR_W | Fill line address |
| fill_state | input | 2 | State written by the fill |
| ld_addr | input | ADDR_W | Lookup address for a local load |
| ld_hit | output | 1 | Lookup found a valid line with matching tag |
| ld_state | output | 2 | State of the looked-up set's line |
| fence_ld | input | 1 | Load fence |
| fence_full | input | 1 | Full fence (load part handled here) |
| load_permit | output | 1 | Later loads may complete |

## Verification
The hardest condition to create from the ports is a queue that holds invalidations for several cycles. Without help, each entry is applied one cycle after it arrives, so the stale-read window, back-pressure and a fence over a non-empty queue would never be seen. The stimulus holds `fill_valid` high with harmless fills to a spare set, which keeps the update port busy and freezes application. It then pushes requests, looks up stale lines, fills the queue to DEPTH and raises a fence. Finally it releases the port and counts the exact cycle in which `load_permit` returns.

// File: rtl/invq_pkg.sv
package invq_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;
endpackage

// File: rtl/invq_fifo.sv
module invq_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= adv(wr_q);
      if (pop)  rd_q <= adv(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = slot_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R2: the port logic never pushes into a full queue
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: application only draws from a non-empty queue
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/invq_line_array.sv
module invq_line_array
  import invq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  line_st_e          fill_st,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output line_st_e          lk_st
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [TAG_W-1:0] tag_q [SETS];
  line_st_e         st_q  [SETS];

  logic [SET_W-1:0] fset, iset, lset;
  logic [TAG_W-1:0] ftag, itag, ltag;
  logic             inv_match;

  assign fset = fill_addr[SET_W-1:0];
  assign ftag = fill_addr[ADDR_W-1:SET_W];
  assign iset = inv_addr[SET_W-1:0];
  assign itag = inv_addr[ADDR_W-1:SET_W];
  assign lset = lk_addr[SET_W-1:0];
  assign ltag = lk_addr[ADDR_W-1:SET_W];

  assign inv_match = (st_q[iset] != LS_I) && (tag_q[iset] == itag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
      end
    end else if (fill_en) begin
      st_q[fset]  <= fill_st;
      tag_q[fset] <= ftag;
    end else if (inv_en && inv_match) begin
      st_q[iset] <= LS_I;
    end
  end

  assign lk_hit = (st_q[lset] != LS_I) && (tag_q[lset] == ltag);
  assign lk_st  = st_q[lset];

  // R3: fills and invalidations never share the update port in one cycle
  p_port_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> !fill_en);
  // R4: a matching line is Invalid after its invalidation is applied
  p_apply_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_match) |=> (st_q[$past(iset)] == LS_I));
  // R5: an absent line leaves its set untouched
  p_absent_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !inv_match) |=> (st_q[$past(iset)] == $past(st_q[iset])));
endmodule

// File: rtl/invq_fence_ctrl.sv
module invq_fence_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fence_ld,
  input  logic fence_full,
  input  logic q_empty,
  output logic load_permit
);
  logic fence_any;
  logic pend_q;

  assign fence_any = fence_ld | fence_full;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (fence_any) pend_q <= 1'b1;
    else if (q_empty)   pend_q <= 1'b0;
  end

  assign load_permit = !(fence_any || pend_q);

  // R7: a pending fence is released once the queue has drained
  p_drain_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && q_empty && !fence_any) |=> !pend_q);
  // R9: loads are only permitted again after an empty queue was seen
  p_permit_after_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_permit) |-> $past(q_empty));
endmodule

// File: rtl/inval_queue.sv
module inval_queue
  import invq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  output logic              inv_ready,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              apply_valid,
  output logic [ADDR_W-1:0] apply_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [1:0]        ld_state,
  input  logic              fence_ld,
  input  logic              fence_full,
  output logic              load_permit
);
  logic     q_push, q_empty, q_full;
  line_st_e lk_st;

  assign inv_ready   = !q_full;
  assign q_push      = inv_valid && inv_ready;
  assign apply_valid = !q_empty && !fill_valid;

  invq_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (inv_addr),
    .pop   (apply_valid),
    .dout  (apply_addr),
    .empty (q_empty),
    .full  (q_full)
  );

  invq_line_array #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_valid),
    .fill_addr (fill_addr),
    .fill_st   (line_st_e'(fill_state)),
    .inv_en    (apply_valid),
    .inv_addr  (apply_addr),
    .lk_addr   (ld_addr),
    .lk_hit    (ld_hit),
    .lk_st     (lk_st)
  );

  assign ld_state = lk_st;

  invq_fence_ctrl u_fence (
    .clk         (clk),
    .rst_n       (rst_n),
    .fence_ld    (fence_ld),
    .fence_full  (fence_full),
    .q_empty     (q_empty),
    .load_permit (load_permit)
  );

  // R1: an acknowledged request is held in the queue on the next cycle
  p_ack_queued_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> !q_empty);
endmodule

// File: tb/inval_queue_test.sv
module inval_queue_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inv_valid = 1'b0;
  logic              inv_ready;
  logic [ADDR_W-1:0] inv_addr = '0;
  logic              apply_valid;
  logic [ADDR_W-1:0] apply_addr;
  logic              fill_valid = 1'b0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [1:0]        fill_state = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic              ld_hit;
  logic [1:0]        ld_state;
  logic              fence_ld = 1'b0;
  logic              fence_full = 1'b0;
  logic              load_permit;

  int total = 0;
  int bad   = 0;
  logic [ADDR_W-1:0] exp_q [$];

  inval_queue uut (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr),
    .apply_valid(apply_valid), .apply_addr(apply_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_state(fill_state),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_state(ld_state),
    .fence_ld(fence_ld), .fence_full(fence_full), .load_permit(load_permit)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: entered and left at a falling edge
  task automatic push_inv(input logic [ADDR_W-1:0] a);
    inv_valid = 1'b1;
    inv_addr  = a;
    #1 chk("R1 ready before push", inv_ready, 1);
    exp_q.push_back(a);
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input logic [1:0] st);
    fill_valid = 1'b1;
    fill_addr  = a;
    fill_state = st;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic hold_port(input logic on);
    fill_valid = on;
    fill_addr  = 12'h0F7;
    fill_state = 2'd1;
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input string req,
                      input int hit, input int st);
    ld_addr = a;
    #1;
    chk(req, ld_hit, hit);
    if (hit == 1) chk(req, ld_state, st);
  endtask

  // monitor: scoreboard of applied addresses
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && apply_valid) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R3 apply order actual=%0d expected=none", apply_addr);
        end else begin
          logic [ADDR_W-1:0] e;
          e = exp_q.pop_front();
          if (apply_addr !== e) begin
            bad++;
            $display("FAIL R3 apply order actual=%0d expected=%0d", apply_addr, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(12'h011, "R10 reset no hit", 0, 0);
    chk("R10 reset ready", inv_ready, 1);
    chk("R10 reset permit", load_permit, 1);
    chk("R10 reset apply idle", apply_valid, 0);

    fill(12'h011, 2'd1);
    fill(12'h022, 2'd2);
    fill(12'h033, 2'd3);
    fill(12'h044, 2'd1);
    look(12'h033, "R4 setup fill", 1, 3);

    // stale window: port held busy so the entry stays queued
    hold_port(1'b1);
    push_inv(12'h011);
    look(12'h011, "R6 stale hit after ack", 1, 1);
    chk("R3 fill blocks apply", apply_valid, 0);
    hold_port(1'b0);
    @(negedge clk);
    look(12'h011, "R4 shared line invalidated", 0, 0);

    // absent line: tag mismatch in set 4
    push_inv(12'h144);
    @(negedge clk);
    look(12'h044, "R5 mismatch leaves line", 1, 1);

    // back-pressure and load fence over a full queue
    hold_port(1'b1);
    push_inv(12'h022);
    push_inv(12'h033);
    push_inv(12'h044);
    push_inv(12'h155);
    #1 chk("R2 full queue not ready", inv_ready, 0);
    look(12'h022, "R6 exclusive still stale", 1, 2);
    fence_ld = 1'b1;
    #1 chk("R7 permit low in fence cycle", load_permit, 0);
    @(negedge clk);
    fence_ld = 1'b0;
    #1 chk("R7 permit low while pending", load_permit, 0);
    chk("R2 still not ready", inv_ready, 0);
    hold_port(1'b0);
    repeat (4) @(negedge clk);
    #1 chk("R7 permit low at drain", load_permit, 0);
    chk("R2 ready after drain", inv_ready, 1);
    @(negedge clk);
    #1 chk("R7 permit returns", load_permit, 1);
    look(12'h022, "R9 no stale exclusive", 0, 0);
    look(12'h033, "R9 no stale modified", 0, 0);
    look(12'h044, "R9 no stale shared", 0, 0);

    // full fence
    @(negedge clk);
    fill(12'h011, 2'd1);
    hold_port(1'b1);
    push_inv(12'h011);
    fence_full = 1'b1;
    #1 chk("R8 full fence blocks", load_permit, 0);
    @(negedge clk);
    fence_full = 1'b0;
    hold_port(1'b0);
    @(negedge clk);
    #1 chk("R8 permit low at drain", load_permit, 0);
    @(negedge clk);
    #1 chk("R8 permit returns", load_permit, 1);
    look(12'h011, "R9 full fence no stale", 0, 0);

    // fence with nothing queued
    fence_ld = 1'b1;
    #1 chk("R7 empty fence cycle", load_permit, 0);
    @(negedge clk);
    fence_ld = 1'b0;
    #1 chk("R7 empty fence second", load_permit, 0);
    @(negedge clk);
    #1 chk("R7 empty fence release", load_permit, 1);

    repeat (3) @(negedge clk);
    chk("R3 all applied", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule